// File: doc/BRIEF.md
# Cascadable Two-Tap Complex Adaptive Equalizer Slice

This block is one slice of a complex-valued adaptive equalizer with decision feedback. Each slice holds two complex taps. Each tap has its own coefficient register, adapted by a least-mean-squares rule from a complex error that all slices share. Slices are placed in series to build longer filters. The delayed-sample output of one slice drives the sample input of the next, and the partial-sum output of one slice drives the partial-sum input of the next.

A one-bit role input picks the slice's function:

- **Feed-forward role.** The slice filters received samples and adds its tap products to the running sum.
- **Feedback role.** The slice filters past hard decisions and subtracts its tap products. Its coefficient update changes sign to match.

The partial sum moves between taps and slices as a redundant binary number, carried as a positive and a negative bit vector. Each tap therefore costs one multiply and one carry-free digit add. A two's complement copy of the slice's outgoing sum is also provided. Only the copy from the last slice in the chain is meant to be used.

The sample delay line and the coefficient update advance only on cycles where the valid strobe is high. A synchronous init input loads the start-up coefficients.

Top module: `cdfe_slice`

## Requirements
- R1: In the feed-forward role (`role_i`=0), the value of the partial-sum output equals the value of the partial-sum input plus w0·x(n) + w1·x(n-1), computed in complex arithmetic modulo 2^SW. Here x(n) is `x_*_i` and x(n-1) is the sample taken at the last valid strobe.
- R2: In the feedback role (`role_i`=1), the value of the partial-sum output equals the value of the partial-sum input minus w0·x(n) + w1·x(n-1), modulo 2^SW.
- R3: A redundant binary partial sum has the value P − N modulo 2^SW, where P is the positive vector and N is the negative vector. Any bit pattern is accepted, including digits with both bits set, which count as zero. Every internal sum digit stays within {−1, 0, +1}.
- R4: The sample outputs `x_*_o` present the sample that was taken two valid strobes earlier. This feeds the next slice's tap 0.
- R5: While `valid_i` is low and `init_i` is low, the delay line and both coefficients hold their values, whatever the error, the samples and the step size are.
- R6: In the feed-forward role, with `valid_i` high, each tap updates w ← w + ((e·conj(x_k)) >>> mu_shift). The shift is an arithmetic (flooring) shift applied separately to the real and imaginary parts. x_k is the sample the tap sees in that cycle.
- R7: In the feedback role the update is w ← w − ((e·conj(x_k)) >>> mu_shift).
- R8: Each updated coefficient part saturates to the signed CW-bit range [−2^(CW−1), 2^(CW−1)−1].
- R9: Reset clears the delay line and all coefficients.
  - With `init_i` high in the feed-forward role, the next edge loads tap 0 with 2^CFRAC + 0j (unity) and tap 1 with zero.
  - In the feedback role, init clears both taps.
  - Init acts without `valid_i` and takes priority over the coefficient update.
- R10: `y_re_o`/`y_im_o` equal the two's complement value (P − N modulo 2^SW) of the partial-sum output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_i | input | 1 | 0 = feed-forward role, 1 = feedback role |
| init_i | input | 1 | Load start-up coefficients |
| valid_i | input | 1 | Advance the delay line and adapt the coefficients |
| mu_shift_i | input | MUW | Step size as a right-shift count |
| x_re_i | input | DW | Sample input, real part (signed) |
| x_im_i | input | DW | Sample input, imaginary part (signed) |
| err_re_i | input | DW | Shared error, real part (signed) |
| err_im_i | input | DW | Shared error, imaginary part (signed) |
| ps_re_p_i | input | SW | Partial-sum input, real part, positive vector |
| ps_re_n_i | input | SW | Partial-sum input, real part, negative vector |
| ps_im_p_i | input | SW | Partial-sum input, imaginary part, positive vector |
| ps_im_n_i | input | SW | Partial-sum input, imaginary part, negative vector |
| x_re_o | output | DW | Delayed sample for the next slice, real part |
| x_im_o | output | DW | Delayed sample for the next slice, imaginary part |
| ps_re_p_o | output | SW | Partial-sum output, real part, positive vector |
| ps_re_n_o | output | SW | Partial-sum output, real part, negative vector |
| ps_im_p_o | output | SW | Partial-sum output, imaginary part, positive vector |
| ps_im_n_o | output | SW | Partial-sum output, imaginary part, negative vector |
| y_re_o | output | SW | Two's complement of the partial-sum output, real part |
| y_im_o | output | SW | Two's complement of the partial-sum output, imaginary part |

## Verification
The coefficients have no port of their own, which makes them the hardest state to reach. They can only be seen through the filter sum, so the bench keeps a model of both taps and of the delay line, and checks every complex output against it after each adaptation step.

Saturation at both rails needs errors and samples near full scale with no shift. The bench drives exactly that, then flips the error's sign to reach the opposite rail.

The carry-free adder is pushed with random redundant partial sums whose digits are often both set. These patterns exercise every branch of the digit rule, which ordinary two's complement sums never reach.

// File: rtl/eq_pkg.sv
package eq_pkg;

    typedef enum logic {
        ROLE_FF = 1'b0,
        ROLE_FB = 1'b1
    } role_e;

    // One redundant binary digit step: carry to the next digit and residual digit.
    typedef struct packed {
        logic signed [1:0] carry;
        logic signed [1:0] resid;
    } rb_step_t;

    // t is the sum of two input digits (-2..2).
    // lower_neg is set when a digit below holds -1.
    function automatic rb_step_t rb_digit_step(input int t, input logic lower_neg);
        rb_step_t r;
        r.carry = 2'sd0;
        r.resid = 2'sd0;
        case (t)
            2:  r.carry = 2'sd1;
            1:  begin
                    r.carry = lower_neg ? 2'sd0 : 2'sd1;
                    r.resid = lower_neg ? 2'sd1 : -2'sd1;
                end
            -1: begin
                    r.carry = lower_neg ? -2'sd1 : 2'sd0;
                    r.resid = lower_neg ? 2'sd1 : -2'sd1;
                end
            -2: r.carry = -2'sd1;
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rb_adder.sv
module rb_adder #(
    parameter int W = 26
) (
    input  logic [W-1:0] a_p,
    input  logic [W-1:0] a_n,
    input  logic [W-1:0] b_p,
    input  logic [W-1:0] b_n,
    output logic [W-1:0] z_p,
    output logic [W-1:0] z_n
);
    import eq_pkg::*;

    logic [W-1:0] dig_neg;
    logic [W-1:0] neg_below;

    assign dig_neg   = (a_n & ~a_p) | (b_n & ~b_p);
    assign neg_below = {dig_neg[W-2:0], 1'b0};

    always_comb begin
        int               t;
        int               zv;
        rb_step_t         st;
        logic signed [1:0] cin;
        z_p = '0;
        z_n = '0;
        cin = 2'sd0;
        for (int i = 0; i < W; i++) begin
            t  = (int'(a_p[i]) - int'(a_n[i])) + (int'(b_p[i]) - int'(b_n[i]));
            st = rb_digit_step(t, neg_below[i]);
            zv = int'(st.resid) + int'(cin);
            assert_digit_range_R3: assert (zv >= -1 && zv <= 1)
                else $error("redundant digit out of range at %0d", i);
            z_p[i] = (zv == 1);
            z_n[i] = (zv == -1);
            cin    = st.carry;
        end
        assert_rb_sum_R3: assert ((z_p - z_n) == ((a_p - a_n) + (b_p - b_n)))
            else $error("redundant sum value mismatch");
    end

endmodule

// File: rtl/cplx_tap.sv
module cplx_tap #(
    parameter int DW = 10,
    parameter int CW = 12,
    parameter int SW = 26
) (
    input  logic signed [CW-1:0] w_re,
    input  logic signed [CW-1:0] w_im,
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic                 negate,
    input  logic [SW-1:0]        pin_re_p,
    input  logic [SW-1:0]        pin_re_n,
    input  logic [SW-1:0]        pin_im_p,
    input  logic [SW-1:0]        pin_im_n,
    output logic [SW-1:0]        pout_re_p,
    output logic [SW-1:0]        pout_re_n,
    output logic [SW-1:0]        pout_im_p,
    output logic [SW-1:0]        pout_im_n
);
    localparam int PW = DW + CW;

    logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic [SW-1:0] pr_p, pr_n, pi_p, pi_n;
    logic [SW-1:0] ar_p, ar_n, ai_p, ai_n;

    assign m_rr = PW'(w_re) * PW'(x_re);
    assign m_ii = PW'(w_im) * PW'(x_im);
    assign m_ri = PW'(w_re) * PW'(x_im);
    assign m_ir = PW'(w_im) * PW'(x_re);

    // Real part: wr*xr - wi*xi falls out as positive/negative vectors.
    assign pr_p = SW'(m_rr);
    assign pr_n = SW'(m_ii);
    // Imaginary part: wr*xi + wi*xr, the second term stored negated in the negative vector.
    assign pi_p = SW'(m_ri);
    assign pi_n = -SW'(m_ir);

    // Negation of a redundant number is a swap of its vectors.
    assign ar_p = negate ? pr_n : pr_p;
    assign ar_n = negate ? pr_p : pr_n;
    assign ai_p = negate ? pi_n : pi_p;
    assign ai_n = negate ? pi_p : pi_n;

    rb_adder #(.W(SW)) u_add_re (
        .a_p(pin_re_p), .a_n(pin_re_n), .b_p(ar_p), .b_n(ar_n),
        .z_p(pout_re_p), .z_n(pout_re_n)
    );

    rb_adder #(.W(SW)) u_add_im (
        .a_p(pin_im_p), .a_n(pin_im_n), .b_p(ai_p), .b_n(ai_n),
        .z_p(pout_im_p), .z_n(pout_im_n)
    );

endmodule

// File: rtl/coef_lms.sv
module coef_lms #(
    parameter int DW    = 10,
    parameter int CW    = 12,
    parameter int CFRAC = 10,
    parameter int MUW   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  logic                 init,
    input  logic                 init_unity,
    input  logic                 negate,
    input  logic [MUW-1:0]       mu,
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [DW-1:0] e_re,
    input  logic signed [DW-1:0] e_im,
    output logic signed [CW-1:0] w_re_o,
    output logic signed [CW-1:0] w_im_o
);
    localparam int GW   = 2 * DW + 1;
    localparam int AW   = ((CW > GW) ? CW : GW) + 2;
    localparam int CMAX = (1 << (CW - 1)) - 1;
    localparam int CMIN = -(1 << (CW - 1));
    localparam logic signed [CW-1:0] UNITY = CW'(1 << CFRAC);

    logic signed [AW-1:0] g_re, g_im, d_re, d_im, n_re, n_im;

    // e * conj(x)
    assign g_re = AW'(e_re) * AW'(x_re) + AW'(e_im) * AW'(x_im);
    assign g_im = AW'(e_im) * AW'(x_re) - AW'(e_re) * AW'(x_im);
    assign d_re = g_re >>> mu;
    assign d_im = g_im >>> mu;
    assign n_re = negate ? (AW'(w_re_o) - d_re) : (AW'(w_re_o) + d_re);
    assign n_im = negate ? (AW'(w_im_o) - d_im) : (AW'(w_im_o) + d_im);

    function automatic logic signed [CW-1:0] clip(input logic signed [AW-1:0] v);
        if (v > AW'(CMAX)) return CW'(CMAX);
        if (v < AW'(CMIN)) return CW'(CMIN);
        return v[CW-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            w_re_o <= '0;
            w_im_o <= '0;
        end else if (init) begin
            w_re_o <= init_unity ? UNITY : '0;
            w_im_o <= '0;
        end else if (valid) begin
            w_re_o <= clip(n_re);
            w_im_o <= clip(n_im);
        end
    end

    assert_coef_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!valid && !init) |=> ($stable(w_re_o) && $stable(w_im_o)))
        else $error("coefficient moved without valid");

    assert_init_load_R9: assert property (@(posedge clk) disable iff (rst)
        init |=> (w_im_o == '0 && (w_re_o == UNITY || w_re_o == '0)))
        else $error("init did not load start-up coefficient");

endmodule

// File: rtl/cdfe_slice.sv
module cdfe_slice #(
    parameter int DW    = 10,
    parameter int CW    = 12,
    parameter int CFRAC = 10,
    parameter int GUARD = 4,
    parameter int MUW   = 4,
    localparam int SW   = DW + CW + GUARD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 role_i,
    input  logic                 init_i,
    input  logic                 valid_i,
    input  logic [MUW-1:0]       mu_shift_i,
    input  logic signed [DW-1:0] x_re_i,
    input  logic signed [DW-1:0] x_im_i,
    input  logic signed [DW-1:0] err_re_i,
    input  logic signed [DW-1:0] err_im_i,
    input  logic [SW-1:0]        ps_re_p_i,
    input  logic [SW-1:0]        ps_re_n_i,
    input  logic [SW-1:0]        ps_im_p_i,
    input  logic [SW-1:0]        ps_im_n_i,
    output logic signed [DW-1:0] x_re_o,
    output logic signed [DW-1:0] x_im_o,
    output logic [SW-1:0]        ps_re_p_o,
    output logic [SW-1:0]        ps_re_n_o,
    output logic [SW-1:0]        ps_im_p_o,
    output logic [SW-1:0]        ps_im_n_o,
    output logic signed [SW-1:0] y_re_o,
    output logic signed [SW-1:0] y_im_o
);
    import eq_pkg::*;

    localparam int NTAP = 2;

    role_e role;
    logic  fb_mode;
    assign role    = role_e'(role_i);
    assign fb_mode = (role == ROLE_FB);

    logic signed [DW-1:0] dly_re [NTAP];
    logic signed [DW-1:0] dly_im [NTAP];
    logic signed [DW-1:0] tx_re  [NTAP];
    logic signed [DW-1:0] tx_im  [NTAP];
    logic signed [CW-1:0] w_re   [NTAP];
    logic signed [CW-1:0] w_im   [NTAP];
    logic [SW-1:0] c_re_p [NTAP+1];
    logic [SW-1:0] c_re_n [NTAP+1];
    logic [SW-1:0] c_im_p [NTAP+1];
    logic [SW-1:0] c_im_n [NTAP+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NTAP; k++) begin
                dly_re[k] <= '0;
                dly_im[k] <= '0;
            end
        end else if (valid_i) begin
            dly_re[0] <= x_re_i;
            dly_im[0] <= x_im_i;
            for (int k = 1; k < NTAP; k++) begin
                dly_re[k] <= dly_re[k-1];
                dly_im[k] <= dly_im[k-1];
            end
        end
    end

    assign tx_re[0] = x_re_i;
    assign tx_im[0] = x_im_i;
    assign c_re_p[0] = ps_re_p_i;
    assign c_re_n[0] = ps_re_n_i;
    assign c_im_p[0] = ps_im_p_i;
    assign c_im_n[0] = ps_im_n_i;

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        if (k > 0) begin : g_tx
            assign tx_re[k] = dly_re[k-1];
            assign tx_im[k] = dly_im[k-1];
        end

        coef_lms #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .MUW(MUW)) u_coef (
            .clk(clk), .rst(rst), .valid(valid_i), .init(init_i),
            .init_unity((k == 0) && !fb_mode), .negate(fb_mode), .mu(mu_shift_i),
            .x_re(tx_re[k]), .x_im(tx_im[k]), .e_re(err_re_i), .e_im(err_im_i),
            .w_re_o(w_re[k]), .w_im_o(w_im[k])
        );

        cplx_tap #(.DW(DW), .CW(CW), .SW(SW)) u_tap (
            .w_re(w_re[k]), .w_im(w_im[k]), .x_re(tx_re[k]), .x_im(tx_im[k]),
            .negate(fb_mode),
            .pin_re_p(c_re_p[k]), .pin_re_n(c_re_n[k]),
            .pin_im_p(c_im_p[k]), .pin_im_n(c_im_n[k]),
            .pout_re_p(c_re_p[k+1]), .pout_re_n(c_re_n[k+1]),
            .pout_im_p(c_im_p[k+1]), .pout_im_n(c_im_n[k+1])
        );
    end

    assign x_re_o    = dly_re[NTAP-1];
    assign x_im_o    = dly_im[NTAP-1];
    assign ps_re_p_o = c_re_p[NTAP];
    assign ps_re_n_o = c_re_n[NTAP];
    assign ps_im_p_o = c_im_p[NTAP];
    assign ps_im_n_o = c_im_n[NTAP];
    assign y_re_o    = ps_re_p_o - ps_re_n_o;
    assign y_im_o    = ps_im_p_o - ps_im_n_o;

    assert_dly_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(x_re_o) && $stable(x_im_o)))
        else $error("delay line moved without valid");

endmodule

// File: tb/cdfe_slice_tb.sv
`timescale 1ns/1ps
module cdfe_slice_tb_top;
    localparam int DW = 10, CW = 12, CFRAC = 10, GUARD = 4, MUW = 4;
    localparam int SW = DW + CW + GUARD;
    localparam longint CMAX = (64'sd1 <<< (CW - 1)) - 1;
    localparam longint CMIN = -(64'sd1 <<< (CW - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic role_i = 1'b0, init_i = 1'b0, valid_i = 1'b0;
    logic [MUW-1:0] mu_shift_i = '0;
    logic signed [DW-1:0] x_re_i = '0, x_im_i = '0, err_re_i = '0, err_im_i = '0;
    logic [SW-1:0] ps_re_p_i = '0, ps_re_n_i = '0, ps_im_p_i = '0, ps_im_n_i = '0;
    logic signed [DW-1:0] x_re_o, x_im_o;
    logic [SW-1:0] ps_re_p_o, ps_re_n_o, ps_im_p_o, ps_im_n_o;
    logic signed [SW-1:0] y_re_o, y_im_o;

    cdfe_slice #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .GUARD(GUARD), .MUW(MUW)) dut_i (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference state derived from the requirements.
    longint w0r = 0, w0i = 0, w1r = 0, w1i = 0;
    longint d1r = 0, d1i = 0, d2r = 0, d2i = 0;

    function automatic longint wrap(input longint v);
        return (v <<< (64 - SW)) >>> (64 - SW);
    endfunction

    function automatic longint clip(input longint v);
        if (v > CMAX) return CMAX;
        if (v < CMIN) return CMIN;
        return v;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle: set inputs away from the edge, check outputs, then update the model at the edge.
    task automatic step(input longint xr, input longint xi, input longint er, input longint ei,
                        input logic v, input logic ini, input string req);
        longint s, pr, pi, er_y, ei_y, gr, gi;
        @(negedge clk);
        x_re_i = DW'(xr); x_im_i = DW'(xi);
        err_re_i = DW'(er); err_im_i = DW'(ei);
        valid_i = v; init_i = ini;
        #1;
        s  = role_i ? -1 : 1;
        pr = longint'(ps_re_p_i) - longint'(ps_re_n_i);
        pi = longint'(ps_im_p_i) - longint'(ps_im_n_i);
        er_y = wrap(pr + s * (w0r * xr - w0i * xi + w1r * d1r - w1i * d1i));
        ei_y = wrap(pi + s * (w0r * xi + w0i * xr + w1r * d1i + w1i * d1r));
        check(req, "y_re", longint'(y_re_o), er_y);
        check(req, "y_im", longint'(y_im_o), ei_y);
        check("R10", "conv_re", longint'(y_re_o), wrap(longint'(ps_re_p_o) - longint'(ps_re_n_o)));
        check("R4", "x_re_o", longint'(x_re_o), d2r);
        check("R4", "x_im_o", longint'(x_im_o), d2i);
        @(posedge clk);
        if (ini) begin
            w0r = role_i ? 0 : (64'sd1 <<< CFRAC); w0i = 0; w1r = 0; w1i = 0;
        end else if (v) begin
            gr = er * xr + ei * xi; gi = ei * xr - er * xi;
            w0r = clip(w0r + s * (gr >>> mu_shift_i));
            w0i = clip(w0i + s * (gi >>> mu_shift_i));
            gr = er * d1r + ei * d1i; gi = ei * d1r - er * d1i;
            w1r = clip(w1r + s * (gr >>> mu_shift_i));
            w1i = clip(w1i + s * (gi >>> mu_shift_i));
        end
        if (v) begin
            d2r = d1r; d2i = d1i; d1r = xr; d1i = xi;
        end
    endtask

    task automatic t_reset();
        step(100, -50, 0, 0, 1'b0, 1'b0, "R9");
        check("R9", "reset y_re zero", longint'(y_re_o), 0);
    endtask

    task automatic t_init_ff();
        role_i = 1'b0;
        step(0, 0, 0, 0, 1'b0, 1'b1, "R9");
        step(3, -2, 0, 0, 1'b0, 1'b0, "R9");
        check("R9", "unity tap0", longint'(y_re_o), 3 * 1024);
    endtask

    task automatic t_lms_ff();
        mu_shift_i = 4'd3;
        step(40, 20, 0, 0, 1'b1, 1'b0, "R6");
        step(-30, 50, 12, -7, 1'b1, 1'b0, "R6");
        step(25, -15, -9, 4, 1'b1, 1'b0, "R6");
        step(-17, -33, 5, 11, 1'b1, 1'b0, "R6");
        step(8, 9, 0, 0, 1'b0, 1'b0, "R6");
    endtask

    task automatic t_fir();
        step(100, 0, 0, 0, 1'b1, 1'b0, "R1");
        step(-200, 55, 0, 0, 1'b1, 1'b0, "R1");
        step(311, -400, 0, 0, 1'b1, 1'b0, "R4");
        step(-511, 511, 0, 0, 1'b1, 1'b0, "R1");
        step(0, 0, 0, 0, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_psum();
        for (int i = 0; i < 8; i++) begin
            ps_re_p_i = SW'($urandom); ps_re_n_i = SW'($urandom);
            ps_im_p_i = (i % 2 == 0) ? '1 : SW'($urandom);
            ps_im_n_i = (i % 3 == 0) ? '1 : SW'($urandom);
            step(longint'($urandom_range(0, 1000)) - 500, longint'($urandom_range(0, 1000)) - 500,
                 0, 0, 1'b1, 1'b0, "R3");
        end
        ps_re_p_i = '0; ps_re_n_i = '0; ps_im_p_i = '0; ps_im_n_i = '0;
    endtask

    task automatic t_hold();
        mu_shift_i = 4'd0;
        step(77, -66, 300, -300, 1'b0, 1'b0, "R5");
        step(-123, 45, -400, 222, 1'b0, 1'b0, "R5");
        step(10, 10, 0, 0, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_sat();
        mu_shift_i = 4'd0;
        step(511, 0, 511, 0, 1'b1, 1'b0, "R8");
        step(1, 0, 0, 0, 1'b0, 1'b0, "R8");
        check("R8", "tap0 upper rail", longint'(y_re_o), CMAX + w1r * d1r - w1i * d1i);
        step(511, 0, -511, 0, 1'b1, 1'b0, "R8");
        step(-511, 0, -511, 0, 1'b1, 1'b0, "R8");
        step(1, 0, 0, 0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_init_prio();
        mu_shift_i = 4'd0;
        step(300, 300, 400, 400, 1'b1, 1'b1, "R9");
        step(5, 0, 0, 0, 1'b0, 1'b0, "R9");
        check("R9", "init beats update", w0r, 1024);
    endtask

    task automatic t_fb();
        role_i = 1'b1;
        step(0, 0, 0, 0, 1'b0, 1'b1, "R9");
        step(9, 9, 0, 0, 1'b0, 1'b0, "R9");
        check("R9", "fb init clears", longint'(y_re_o), 0);
        mu_shift_i = 4'd2;
        step(256, 0, 20, 10, 1'b1, 1'b0, "R7");
        step(-256, 256, -8, 15, 1'b1, 1'b0, "R7");
        step(256, -256, 6, -6, 1'b1, 1'b0, "R7");
        ps_re_p_i = SW'(1000); ps_re_n_i = SW'(37);
        ps_im_p_i = SW'(5);    ps_im_n_i = SW'(900);
        step(300, -120, 0, 0, 1'b1, 1'b0, "R2");
        step(-256, -256, 0, 0, 1'b1, 1'b0, "R2");
        ps_re_p_i = '0; ps_re_n_i = '0; ps_im_p_i = '0; ps_im_n_i = '0;
        role_i = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_init_ff();
        t_lms_ff();
        t_fir();
        t_psum();
        t_hold();
        t_sat();
        t_init_prio();
        t_fb();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule